// File: doc/BRIEF.md
# NAND Controller Register Block with Write Key

This block is the register file of a NAND flash controller. A simple bus port lets software write and read four word registers. Two of them are guarded: the configuration register and the flash timing register. Software may change a guarded register only with the write that comes right after it stores the key value into the lock register. Each unlock is good for one write and no more, so a stray store cannot change how the flash is driven.

The configuration fields drive the rest of the controller as registered outputs: write protect, page size, address cycle count and bus width. The timing register drives a packed timing word. A status register combines the device-ready and controller-ready inputs with the outcome of the last ECC decode. That outcome is taken when a decode-done pulse arrives and is cleared when software reads the status register. The pin timing engine and the ECC arithmetic are outside this block.

Top module: `nand_csr`

## Requirements
- R1: After reset the configuration register, the timing register, the unlock state and the ECC status bits are all zero, and no read data is marked valid.
- R2: A bus write to address 0 (the lock register) whose low 16 bits equal 0xA25E unlocks the guarded registers. The upper bits are ignored, and any other value leaves the block locked. Reading address 0 returns the unlock state in bit 0.
- R3: A write to address 1 (configuration) or address 2 (timing) while the block is locked has no effect.
- R4: Every bus write other than a key write locks the block again. This includes the guarded write itself, a wrong key, and a write to any other address. One unlock therefore allows exactly one guarded write.
- R5: Configuration bits are taken from write data bits [3:0]: bit 3 write protect, bit 2 large 2048-byte page (0 means 512-byte), bit 1 four address cycles (0 means three), bit 0 16-bit bus (0 means 8-bit). The outputs change at the clock edge of an accepted write. A readback shows bits [3:0] with the upper bits zero.
- R6: The timing register keeps the low TIM_W (default 27) bits of an accepted write, drives them on timing_o and returns them on a read of address 2.
- R7: Status (address 3) bit 0 is device ready and bit 1 is controller ready, each registered one cycle from its input. Bit 2 and the bits above 6 read as zero.
- R8: On a decode-done pulse, status bit 3 takes the error flag. Bits 5:4 take the corrected symbol count (given as 1 to 4) minus one when the error flag is set, and 0 otherwise. Bit 6 takes the uncorrectable flag only when the error flag is set.
- R9: A read of the status register returns the ECC bits and then clears bits 6:3. If a decode-done pulse arrives in the same cycle, the new result is kept.
- R10: Read data appears with rd_valid_o one cycle after rd_en_i. Reads never change the unlock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 2 | Register address: 0 lock, 1 config, 2 timing, 3 status |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| rd_valid_o | output | 1 | Read data valid |
| dev_ready_i | input | 1 | Flash device ready |
| ctl_ready_i | input | 1 | Controller ready |
| dec_done_i | input | 1 | ECC decode finished pulse |
| ecc_err_i | input | 1 | Decode found an error |
| ecc_uncorr_i | input | 1 | Error cannot be corrected |
| ecc_syms_i | input | CNT_W+1 | Corrected symbol count, 1 to 4 |
| cfg_wp_o | output | 1 | Write protect |
| cfg_big_page_o | output | 1 | 2048-byte page selected |
| cfg_four_addr_o | output | 1 | Four address cycles selected |
| cfg_wide_bus_o | output | 1 | 16-bit bus selected |
| timing_o | output | TIM_W | Packed timing word |

## Verification
The guarded write path is tried in four ways: with no unlock, right after a good key, after a key followed by a wrong key, and after a key followed by status reads. Together these separate "unlocked" from "unlocked for one write" and from "any write relocks" while "reads keep the key". Key values with junk in the upper half and with a single bit wrong show that only the low 16 bits are compared, and compared exactly. ECC results are taken with and without the error flag, with counts at both ends, and with a decode pulse landing in the same cycle as a clearing read, which shows whether the capture or the clear has priority.

// File: rtl/nand_csr_pkg.sv
package nand_csr_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_LOCK = 2'd0,
    A_CFG  = 2'd1,
    A_TIME = 2'd2,
    A_STAT = 2'd3
  } csr_addr_e;

  // Field order matches bit positions 3..0 decoded by the flash sequencer
  typedef struct packed {
    logic wp;
    logic big_page;
    logic four_addr;
    logic wide_bus;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/csr_unlock.sv
module csr_unlock #(
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA25E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_lock,
  input  logic [KEY_W-1:0] wkey,
  output logic             unlocked_o
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (rst)        open_q <= 1'b0;
    else if (wr_en) open_q <= wr_lock && (wkey == KEY);
  end

  assign unlocked_o = open_q;

  // R4
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_lock) |=> !unlocked_o);
  // R10
  read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(unlocked_o));
endmodule

// File: rtl/csr_prot_reg.sv
module csr_prot_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)     q_r <= '0;
    else if (we) q_r <= d;
  end

  assign q = q_r;

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/csr_ecc_status.sv
module csr_ecc_status #(
  parameter int CNT_W = 2,
  localparam int CW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_done,
  input  logic             err_i,
  input  logic             unc_i,
  input  logic [CW-1:0]    syms_i,
  input  logic             clr,
  output logic             err_o,
  output logic             unc_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             err_q, unc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CW-1:0]    syms_m1;

  assign syms_m1 = syms_i - CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      unc_q <= 1'b0;
      cnt_q <= '0;
    end else if (dec_done) begin
      err_q <= err_i;
      unc_q <= err_i & unc_i;
      cnt_q <= err_i ? syms_m1[CNT_W-1:0] : '0;
    end else if (clr) begin
      err_q <= 1'b0;
      unc_q <= 1'b0;
      cnt_q <= '0;
    end
  end

  assign err_o = err_q;
  assign unc_o = unc_q;
  assign cnt_o = cnt_q;

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    dec_done |=> (err_o == $past(err_i)));
  // R8
  unc_needs_err_chk: assert property (@(posedge clk) disable iff (rst)
    unc_o |-> err_o);
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !dec_done) |=> (!err_o && !unc_o && cnt_o == '0));
endmodule

// File: rtl/nand_csr.sv
module nand_csr
  import nand_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA25E,
  parameter int TIM_W  = 27,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_valid_o,
  input  logic              dev_ready_i,
  input  logic              ctl_ready_i,
  input  logic              dec_done_i,
  input  logic              ecc_err_i,
  input  logic              ecc_uncorr_i,
  input  logic [CNT_W:0]    ecc_syms_i,
  output logic              cfg_wp_o,
  output logic              cfg_big_page_o,
  output logic              cfg_four_addr_o,
  output logic              cfg_wide_bus_o,
  output logic [TIM_W-1:0]  timing_o
);
  localparam int ST_DEV = 0;
  localparam int ST_CTL = 1;
  localparam int ST_ERR = 3;
  localparam int ST_CNT = 4;
  localparam int ST_UNC = ST_CNT + CNT_W;

  logic             unlocked;
  logic             sel_lock, sel_cfg, sel_time, sel_stat;
  logic             cfg_we, tim_we, stat_clr;
  logic [CFG_W-1:0] cfg_bits;
  cfg_t             cfg_q;
  logic [TIM_W-1:0] tim_q;
  logic             dev_q, ctl_q;
  logic             e_err, e_unc;
  logic [CNT_W-1:0] e_cnt;
  logic [DATA_W-1:0] stat_w, rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic             rv_q;

  assign sel_lock = (addr_i == A_LOCK);
  assign sel_cfg  = (addr_i == A_CFG);
  assign sel_time = (addr_i == A_TIME);
  assign sel_stat = (addr_i == A_STAT);

  assign cfg_we   = wr_en_i && sel_cfg  && unlocked;
  assign tim_we   = wr_en_i && sel_time && unlocked;
  assign stat_clr = rd_en_i && sel_stat;

  csr_unlock #(.KEY_W(KEY_W), .KEY(KEY)) u_key (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_lock(sel_lock),
    .wkey(wdata_i[KEY_W-1:0]), .unlocked_o(unlocked)
  );

  csr_prot_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .d(wdata_i[CFG_W-1:0]), .q(cfg_bits)
  );
  assign cfg_q = cfg_t'(cfg_bits);

  csr_prot_reg #(.W(TIM_W)) u_tim (
    .clk(clk), .rst(rst), .we(tim_we), .d(wdata_i[TIM_W-1:0]), .q(tim_q)
  );

  generate
    if (TIM_W < DATA_W) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:TIM_W];
    end
  endgenerate

  csr_ecc_status #(.CNT_W(CNT_W)) u_ecc (
    .clk(clk), .rst(rst), .dec_done(dec_done_i), .err_i(ecc_err_i),
    .unc_i(ecc_uncorr_i), .syms_i(ecc_syms_i), .clr(stat_clr),
    .err_o(e_err), .unc_o(e_unc), .cnt_o(e_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_q <= 1'b0;
      ctl_q <= 1'b0;
    end else begin
      dev_q <= dev_ready_i;
      ctl_q <= ctl_ready_i;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[ST_DEV] = dev_q;
    stat_w[ST_CTL] = ctl_q;
    stat_w[ST_ERR] = e_err;
    stat_w[ST_CNT +: CNT_W] = e_cnt;
    stat_w[ST_UNC] = e_unc;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_LOCK:  rd_mux[0] = unlocked;
      A_CFG:   rd_mux[CFG_W-1:0] = cfg_bits;
      A_TIME:  rd_mux[TIM_W-1:0] = tim_q;
      default: rd_mux = stat_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      rv_q    <= 1'b0;
    end else begin
      rv_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o         = rdata_q;
  assign rd_valid_o      = rv_q;
  assign cfg_wp_o        = cfg_q.wp;
  assign cfg_big_page_o  = cfg_q.big_page;
  assign cfg_four_addr_o = cfg_q.four_addr;
  assign cfg_wide_bus_o  = cfg_q.wide_bus;
  assign timing_o        = tim_q;

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == A_LOCK && wdata_i[KEY_W-1:0] == KEY) |=> unlocked);
  // R3
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == A_CFG && !unlocked) |=> $stable(cfg_bits));
  // R3
  tim_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == A_TIME && !unlocked) |=> $stable(timing_o));
  // R5
  cfg_take_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == A_CFG && unlocked) |=>
      (cfg_wp_o == $past(wdata_i[3]) && cfg_wide_bus_o == $past(wdata_i[0])));
  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);
  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_valid_o);
endmodule

// File: tb/sim_nand_csr.sv
module sim_nand_csr;
  localparam int CLK_NS = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_valid;
  logic dev_rdy = 1'b0, ctl_rdy = 1'b0;
  logic dec_done = 1'b0, e_err = 1'b0, e_unc = 1'b0;
  logic [2:0] e_syms = 3'd1;
  logic wp, bigp, four, wide;
  logic [26:0] tim;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  nand_csr u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .dev_ready_i(dev_rdy), .ctl_ready_i(ctl_rdy), .dec_done_i(dec_done),
    .ecc_err_i(e_err), .ecc_uncorr_i(e_unc), .ecc_syms_i(e_syms),
    .cfg_wp_o(wp), .cfg_big_page_o(bigp), .cfg_four_addr_o(four),
    .cfg_wide_bus_o(wide), .timing_o(tim)
  );

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data emerges
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: unexpected read data 0x%08h expected none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic decode(input logic err, input logic unc, input logic [2:0] syms);
    @(negedge clk);
    dec_done = 1'b1; e_err = err; e_unc = unc; e_syms = syms;
    @(negedge clk);
    dec_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({28'd0, wp, bigp, four, wide}, 32'h0, "R1 cfg outputs");
    chk({5'd0, tim}, 32'h0, "R1 timing");
    chk({31'd0, rd_valid}, 32'h0, "R1 rd_valid");
    rd(2'd0, 32'h0, "R1 lock");
    rd(2'd1, 32'h0, "R1 cfg");
    rd(2'd3, 32'h0, "R1 status");

    // R3 write without unlock ignored
    wr(2'd1, 32'hF);
    chk({28'd0, wp, bigp, four, wide}, 32'h0, "R3 cfg outputs");
    rd(2'd1, 32'h0, "R3 cfg readback");

    // R2 unlock, R5 field positions
    wr(2'd0, 32'h0000A25E);
    rd(2'd0, 32'h1, "R2 lock reads open");
    wr(2'd1, 32'hA);
    chk({28'd0, wp, bigp, four, wide}, 32'hA, "R5 cfg outputs wp+four");
    rd(2'd1, 32'hA, "R5 cfg readback");
    rd(2'd0, 32'h0, "R4 relocked after write");
    wr(2'd1, 32'h5);
    rd(2'd1, 32'hA, "R4 second write ignored");

    // R4 wrong key and other writes relock
    wr(2'd0, 32'h0000A25E);
    wr(2'd0, 32'h00001234);
    wr(2'd2, 32'h123);
    chk({5'd0, tim}, 32'h0, "R4 wrong key relocks");
    wr(2'd0, 32'h0000A25E);
    wr(2'd3, 32'h0);
    wr(2'd1, 32'h1);
    rd(2'd1, 32'hA, "R4 status write relocks");

    // R6 timing width
    wr(2'd0, 32'h0000A25E);
    wr(2'd2, 32'hFFFFFFFF);
    chk({5'd0, tim}, 32'h07FFFFFF, "R6 timing out");
    rd(2'd2, 32'h07FFFFFF, "R6 timing readback");

    // R2 exact key, upper bits ignored
    wr(2'd0, 32'h0000A25F);
    rd(2'd0, 32'h0, "R2 near key rejected");
    wr(2'd0, 32'hDEADA25E);
    rd(2'd0, 32'h1, "R2 upper bits ignored");
    // R10 reads keep unlock
    rd(2'd3, 32'h0, "R10 status read");
    wr(2'd1, 32'hFFFFFFF4);
    chk({28'd0, wp, bigp, four, wide}, 32'h4, "R10 unlock survives reads");
    rd(2'd1, 32'h4, "R5 upper cfg bits dropped");

    // R7 ready bits
    @(negedge clk); dev_rdy = 1'b1; ctl_rdy = 1'b0;
    @(negedge clk);
    rd(2'd3, 32'h1, "R7 device ready");
    dev_rdy = 1'b0; ctl_rdy = 1'b1;
    @(negedge clk);
    rd(2'd3, 32'h2, "R7 controller ready");
    dev_rdy = 1'b1;
    @(negedge clk);

    // R8 / R9 ECC capture and clear
    decode(1'b1, 1'b0, 3'd3);
    rd(2'd3, 32'h2B, "R8 corrected 3");
    rd(2'd3, 32'h03, "R9 cleared");
    decode(1'b1, 1'b1, 3'd4);
    rd(2'd3, 32'h7B, "R8 uncorrectable max count");
    rd(2'd3, 32'h03, "R9 cleared again");
    decode(1'b0, 1'b1, 3'd2);
    rd(2'd3, 32'h03, "R8 no error gates fields");
    decode(1'b1, 1'b0, 3'd1);
    rd(2'd3, 32'h0B, "R8 single symbol");

    // R9 decode in same cycle as clearing read
    exp_q.push_back(32'h03);
    tag_q.push_back("R9 old value on collision");
    @(negedge clk);
    rd_en = 1'b1; addr = 2'd3;
    dec_done = 1'b1; e_err = 1'b1; e_unc = 1'b0; e_syms = 3'd2;
    @(negedge clk);
    rd_en = 1'b0; dec_done = 1'b0;
    rd(2'd3, 32'h1B, "R9 capture wins over clear");

    repeat (4) @(negedge clk);
    chk(exp_q.size(), 32'd0, "R10 all reads returned");
    finish_run();
  end
endmodule